// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a four-wire serial slave. It gives a host access to a bank of 8-bit registers through four signals: an active-low select, a serial clock, a serial input and a serial output. The slave runs on a faster system clock. It passes the three serial inputs through two-flop synchronizers and finds the clock and select edges in that system domain. A 16-bit shift register collects each frame. When select is released, the frame is decoded. A write stores its data byte in the addressed register. A read places the addressed register's value into the low byte of the shift register, and that value leaves on the serial output during the next frame.

The serial output is the top bit of the shift register. A second slave can take its input from this output, and it receives the host's bits sixteen serial clocks later. Other on-chip logic can see register contents through a combinational local read port. It also receives a one-cycle write strobe that carries the address and data, and a one-cycle access strobe that carries the address for every read or write.

Top module: `serreg_slave`

## Requirements
- R1: A frame is shifted in MSB first on serial clock rising edges while select is low. In the frame, bit 15 is the operation (0 = write, 1 = read), bits 14..8 are the 7-bit address, and bits 7..0 are the data byte.
- R2: A write frame to an address from 1 to NREGS-1 stores the data byte. The local read port then returns the new value.
- R3: A read frame replaces the low 8 bits of the shift register with the addressed register's value. The next frame then shifts out the read frame's upper byte followed by that value. The dummy data byte of the read frame changes no register.
- R4: When more than 16 bits arrive during one select-low period, only the last 16 bits are decoded.
- R5: The serial output is the shift register MSB and changes only while the serial clock is low. If the previous frame was not a read, a frame shifts out the previous frame's 16 bits unchanged.
- R6: A frame with address 0x00 is a no-op. It changes no register, raises no strobe and loads no read data.
- R7: Each write to a nonzero address raises wr_stb for exactly one system cycle, with wr_addr and wr_data equal to the frame's address and data fields.
- R8: Each read or write to a nonzero address raises acc_stb for one cycle with acc_addr equal to the address. A write raises acc_stb in the same cycle as wr_stb.
- R9: After reset, every register reads 0x00 (the configuration register therefore holds its shutdown value), the serial output is 0, and both strobes are low.
- R10: A write to an address at or above NREGS still raises both strobes but stores nothing. A read of such an address returns 0x00.
- R11: The local read port is combinational. In the cycle where wr_stb is high, it already shows the written value for that address. In the cycle before, it shows the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial clock from host, asynchronous |
| csn_in | input | 1 | Active-low frame select, asynchronous |
| sdi_in | input | 1 | Serial data in |
| sdo_out | output | 1 | Serial data out, MSB of the shift register |
| rd_addr | input | 7 | Local read port address |
| rd_data | output | 8 | Local read port data, combinational |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 7 | Address of the write |
| wr_data | output | 8 | Data of the write |
| acc_stb | output | 1 | One-cycle access strobe for reads and writes |
| acc_addr | output | 7 | Address of the access |

## Verification
Two functions can act in the same system cycle: a serial write committing to the bank, and the local read port looking at that same register. The bench holds rd_addr on the register being written. A monitor records rd_data in the cycle where wr_stb is high and in the cycle before it. The new value must appear in the strobe cycle, and the old value must still be there one cycle earlier. A bound assertion also requires the read port to agree with wr_data whenever the two addresses match during a strobe.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

    localparam int FRAME_W = 16;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_e;

    function automatic logic addr_in_bank(logic [ADDR_W-1:0] a, int nregs);
        return int'(a) < nregs;
    endfunction

    function automatic op_e classify(frame_t f);
        if (f.addr == '0) return OP_NONE;
        return f.rd ? OP_READ : OP_WRITE;
    endfunction

endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
    parameter int               W       = 3,
    parameter logic [W-1:0]     IDLE    = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta[i] <= IDLE[i];
                q[i]    <= IDLE[i];
            end else begin
                meta[i] <= d[i];
                q[i]    <= meta[i];
            end
        end
    end
endmodule

// File: rtl/serreg_shifter.sv
module serreg_shifter
    import serreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              sdi_s,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_byte,
    output frame_t            frame,
    output logic              frame_end,
    output logic              sdo
);
    logic [FRAME_W-1:0] shreg;
    logic               sclk_d;
    logic               csn_d;
    logic               sclk_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            csn_d  <= csn_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign frame_end = csn_s & ~csn_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (!csn_s && sclk_rise) begin
            shreg <= {shreg[FRAME_W-2:0], sdi_s};
        end else if (load_en) begin
            shreg[DATA_W-1:0] <= load_byte;
        end
    end

    // output follows the MSB only during the low phase of the serial clock
    always_ff @(posedge clk) begin
        if (rst)          sdo <= 1'b0;
        else if (!sclk_s) sdo <= shreg[FRAME_W-1];
    end

    assign frame = frame_t'(shreg);
endmodule

// File: rtl/serreg_bank.sv
module serreg_bank
    import serreg_pkg::*;
#(
    parameter int NREGS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] saddr,
    output logic [DATA_W-1:0] sdata,
    input  logic [ADDR_W-1:0] laddr,
    output logic [DATA_W-1:0] ldata
);
    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

    logic [DATA_W-1:0] mem [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        if (g == 0) begin : g_null
            assign mem[g] = '0;
        end else begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)                                  q <= '0;
                else if (we && waddr == ADDR_W'(g))       q <= wdata;
            end
            assign mem[g] = q;
        end
    end

    always_comb begin
        sdata = '0;
        ldata = '0;
        if (addr_in_bank(saddr, NREGS)) sdata = mem[saddr[IDX_W-1:0]];
        if (addr_in_bank(laddr, NREGS)) ldata = mem[laddr[IDX_W-1:0]];
    end
endmodule

// File: rtl/serreg_slave.sv
module serreg_slave
    import serreg_pkg::*;
#(
    parameter int NREGS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_in,
    input  logic              csn_in,
    input  logic              sdi_in,
    output logic              sdo_out,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              acc_stb,
    output logic [ADDR_W-1:0] acc_addr
);
    logic [2:0]        sync_q;
    frame_t            frame;
    logic              frame_end;
    op_e               op;
    logic              do_wr;
    logic              do_rd;
    logic [DATA_W-1:0] serial_rd;

    serreg_sync #(.W(3), .IDLE(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sclk_in, csn_in, sdi_in}),
        .q   (sync_q)
    );

    serreg_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (sync_q[2]),
        .csn_s     (sync_q[1]),
        .sdi_s     (sync_q[0]),
        .load_en   (do_rd),
        .load_byte (serial_rd),
        .frame     (frame),
        .frame_end (frame_end),
        .sdo       (sdo_out)
    );

    always_comb begin
        op    = frame_end ? classify(frame) : OP_NONE;
        do_wr = (op == OP_WRITE);
        do_rd = (op == OP_READ);
    end

    serreg_bank #(.NREGS(NREGS)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (do_wr),
        .waddr (frame.addr),
        .wdata (frame.data),
        .saddr (frame.addr),
        .sdata (serial_rd),
        .laddr (rd_addr),
        .ldata (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_stb   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            acc_stb  <= 1'b0;
            acc_addr <= '0;
        end else begin
            wr_stb  <= do_wr;
            acc_stb <= do_wr | do_rd;
            if (do_wr) begin
                wr_addr <= frame.addr;
                wr_data <= frame.data;
            end
            if (do_wr || do_rd) acc_addr <= frame.addr;
        end
    end
endmodule

// File: rtl/serreg_slave_chk.sv
module serreg_slave_chk
    import serreg_pkg::*;
#(
    parameter int NREGS = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              acc_stb,
    input logic [ADDR_W-1:0] acc_addr
);
    // R7
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R8
    wr_acc_pair_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (acc_stb && acc_addr == wr_addr));

    // R6
    noop_silent_chk: assert property (@(posedge clk) disable iff (rst)
        acc_stb |-> (acc_addr != '0));

    // R11
    same_cycle_view_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && rd_addr == wr_addr && addr_in_bank(wr_addr, NREGS)) |-> (rd_data == wr_data));

    // R10
    outside_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (!addr_in_bank(rd_addr, NREGS)) |-> (rd_data == '0));

    // R9
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wr_stb && !acc_stb));
endmodule

bind serreg_slave serreg_slave_chk #(.NREGS(NREGS)) u_chk (.*);

// File: tb/serreg_slave_bench.sv
`timescale 1ns/1ps
module serreg_slave_bench;
    localparam int NREGS = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk_in = 1'b0;
    logic       csn_in = 1'b1;
    logic       sdi_in = 1'b0;
    logic       sdo_out;
    logic [6:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       wr_stb;
    logic [6:0] wr_addr;
    logic [7:0] wr_data;
    logic       acc_stb;
    logic [6:0] acc_addr;

    always #5 clk = ~clk;

    serreg_slave #(.NREGS(NREGS)) u_serreg_slave (.*);

    int checks = 0;
    int failures = 0;
    logic [7:0]  model [128];
    logic [15:0] exp_shreg = '0;

    int         wr_cnt = 0, acc_cnt = 0;
    logic [6:0] last_wa = '0, last_aa = '0;
    logic [7:0] last_wd = '0;
    logic [7:0] prev_rd = '0;
    logic       r11_hit = 1'b0;
    logic [7:0] r11_new = '0, r11_old = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_stb) begin
                wr_cnt++;
                last_wa = wr_addr;
                last_wd = wr_data;
                if (wr_addr == rd_addr) begin
                    r11_hit = 1'b1;
                    r11_new = rd_data;
                    r11_old = prev_rd;
                end
            end
            if (acc_stb) begin
                acc_cnt++;
                last_aa = acc_addr;
            end
        end
        prev_rd = rd_data;
    end

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_val(input logic [6:0] a);
        if (a == 0 || int'(a) >= NREGS) return 8'h00;
        return model[a];
    endfunction

    function automatic logic [15:0] next_shreg(input logic [15:0] tx);
        if (tx[15] && tx[14:8] != 0) return {tx[15:8], reg_val(tx[14:8])};
        return tx;
    endfunction

    task automatic shift_frame(input logic [31:0] bits, input int n, output logic [15:0] rx);
        rx = '0;
        sclk_in = 1'b0;
        @(negedge clk) csn_in = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            sdi_in = bits[i];
            repeat (4) @(negedge clk);
            if (n - 1 - i < 16) rx = {rx[14:0], sdo_out};
            sclk_in = 1'b1;
            repeat (4) @(negedge clk);
            sclk_in = 1'b0;
        end
        repeat (4) @(negedge clk);
        csn_in = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic run_frame(input logic [31:0] bits, input int n, input string req);
        logic [15:0] rx;
        logic [15:0] tx;
        int          w0, a0;
        w0 = wr_cnt;
        a0 = acc_cnt;
        shift_frame(bits, n, rx);
        // R5 / R3: what leaves is what the shift register held
        check(rx == exp_shreg, req, "shifted-out frame", rx, exp_shreg);
        tx = bits[15:0];
        if (tx[14:8] != 0) begin
            // R8
            check(acc_cnt == a0 + 1 && last_aa == tx[14:8], "R8", "access strobe",
                  {acc_cnt - a0, 1'b0, last_aa}, {32'd1, 1'b0, tx[14:8]});
            if (!tx[15]) begin
                // R7
                check(wr_cnt == w0 + 1 && last_wa == tx[14:8] && last_wd == tx[7:0], "R7",
                      "write strobe", {wr_cnt - w0, last_wa, last_wd}, {32'd1, tx[14:8], tx[7:0]});
            end else begin
                check(wr_cnt == w0, "R3", "read raises no write strobe", wr_cnt - w0, 0);
            end
        end else begin
            // R6
            check(wr_cnt == w0 && acc_cnt == a0, "R6", "no-op strobes",
                  {wr_cnt - w0, acc_cnt - a0}, 0);
        end
        exp_shreg = next_shreg(tx);
        if (!tx[15] && tx[14:8] != 0 && int'(tx[14:8]) < NREGS) model[tx[14:8]] = tx[7:0];
    endtask

    task automatic check_reg(input logic [6:0] a, input string req);
        rd_addr = a;
        @(negedge clk);
        check(rd_data == reg_val(a), req, $sformatf("local read addr %0d", a), rd_data, reg_val(a));
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] seed_val;
        seed_val = $urandom(32'd7301);
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state
        check(sdo_out == 1'b0 && wr_stb == 1'b0 && acc_stb == 1'b0, "R9", "outputs after reset",
              {sdo_out, wr_stb, acc_stb}, 0);
        for (int a = 0; a < NREGS + 2; a++) check_reg(7'(a), "R9");

        // R1 R2: plain write then local read
        run_frame({16'h0, 1'b0, 7'd3, 8'hA5}, 16, "R1");
        check_reg(7'd3, "R2");

        // R3: read with nonzero dummy byte, then a no-op frame clocks out the value
        run_frame({16'h0, 1'b1, 7'd3, 8'h5A}, 16, "R5");
        check_reg(7'd3, "R3");
        run_frame({16'h0, 1'b0, 7'd0, 8'h77}, 16, "R3");

        // R6: no-op frame loaded nothing, so it comes back verbatim
        run_frame({16'h0, 1'b1, 7'd0, 8'h00}, 16, "R6");
        run_frame({16'h0, 1'b0, 7'd0, 8'h00}, 16, "R6");
        check_reg(7'd0, "R6");

        // R10: outside the bank
        run_frame({16'h0, 1'b0, 7'd18, 8'hC3}, 16, "R5");
        check_reg(7'd18, "R10");
        run_frame({16'h0, 1'b1, 7'd18, 8'hFF}, 16, "R5");
        run_frame({16'h0, 1'b0, 7'd0, 8'h00}, 16, "R10");

        // R4: 20 bits, only the last 16 count
        run_frame({12'h0, 4'hF, 1'b0, 7'd11, 8'h3C}, 20, "R5");
        check_reg(7'd11, "R4");
        run_frame({16'h0, 1'b1, 7'd11, 8'h00}, 16, "R4");
        run_frame({16'h0, 1'b0, 7'd0, 8'h00}, 16, "R4");

        // R11: local view during the write strobe cycle
        rd_addr = 7'd5;
        r11_hit = 1'b0;
        run_frame({16'h0, 1'b0, 7'd5, 8'h96}, 16, "R5");
        check(r11_hit && r11_new == 8'h96, "R11", "value in strobe cycle", r11_new, 8'h96);
        check(r11_old == 8'h00, "R11", "value before strobe cycle", r11_old, 8'h00);

        // random mix
        for (int k = 0; k < 90; k++) begin
            logic [31:0] b;
            int          n;
            b = $urandom;
            b[14:8] = 7'($urandom % (NREGS + 4));
            n = ($urandom % 5 == 0) ? 16 + int'($urandom % 8) : 16;
            run_frame(b, n, "R5");
            if (k % 10 == 0) check_reg(7'($urandom % NREGS), "R2");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule